// File: doc/BRIEF.md
# Bus Source-ID Debug Tagger

This block sits at the pin boundary of a multiplexed 32-bit address/data local bus and makes bus traffic traceable. Each cycle it registers the bus value and the address-latch and data-valid strobes that the bus engine produces, and drives them to the external pins. In the same cycle it drives a 5-bit source identifier. This is the identifier of the transaction that owns the current phase when a valid address or data phase is on the bus. At all other times it is the reserved all-ones code. Debug tagging is enabled by a strap that is sampled only while reset is held. With tagging disabled, the identifier pins never leave the reserved code.

A capture monitor inside the block watches the driven pins, as an external logic analyser would. A cycle whose identifier is not the reserved code and whose address-latch strobe is high yields an address capture. A cycle whose identifier is valid and whose data-valid strobe is high yields a data capture. Each capture is reported with a single-cycle valid pulse together with its kind, its 32-bit value and its identifier. When both strobes arrive together, the address wins and an error pulse is raised. Each captured value is also split into SDRAM row, bank and column fields, using the selected port size to skip the unconnected low bits.

Top module: `srcid_debug_tagger`

## Requirements
- R1: While reset is held, and in the first cycle after it, the pins read: identifier 5'h1F, both strobes 0, bus value 0. The capture monitor reads cap_vld 0 and cap_err 0.
- R2: With tagging enabled, bus_src_id equals core_src_id one cycle after a cycle with core_phase_vld high, and equals 5'h1F one cycle after a cycle with core_phase_vld low.
- R3: With tagging disabled, bus_src_id is 5'h1F in every cycle, whatever the inputs.
- R4: The tagging mode is the value of dbg_strap at the last clock edge with rst_n low. Changes of dbg_strap after reset is released have no effect on bus_src_id.
- R5: bus_ad, bus_ale and bus_dval equal core_ad, core_ale and core_dval of the previous cycle.
- R6: One cycle after a pin cycle with bus_ale high and bus_src_id not 5'h1F, the monitor shows cap_vld 1 and cap_is_data 0. It also shows cap_value equal to that bus_ad and cap_id equal to that bus_src_id.
- R7: One cycle after a pin cycle with bus_dval high, bus_ale low and bus_src_id not 5'h1F, the monitor shows cap_vld 1, cap_is_data 1, and the same value and identifier.
- R8: A pin cycle whose identifier is 5'h1F, or whose strobes are both low, gives cap_vld 0 in the following cycle.
- R9: When both strobes are high with a valid identifier, the capture is an address capture (cap_is_data 0) and cap_err is 1 in the same cycle. cap_err is 0 in every other cycle.
- R10: With L low bits given by port_size (0: 0 bits, 1: 1 bit, 2 or 3: 2 bits), the fields are cap_col = cap_value[L +: 10], cap_bank = cap_value[L+10 +: 2] and cap_row = cap_value[L+12 +: 13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_strap | input | 1 | Tagging enable, sampled during reset |
| port_size | input | 2 | Port width code for the SDRAM field split |
| core_ad | input | 32 | Bus value from the bus engine |
| core_ale | input | 1 | Address-latch strobe from the bus engine |
| core_dval | input | 1 | Data-valid strobe from the bus engine |
| core_phase_vld | input | 1 | A valid address or data phase is being driven |
| core_src_id | input | 5 | Identifier of the transaction source |
| bus_ad | output | 32 | Registered bus value pins |
| bus_ale | output | 1 | Registered address-latch strobe pin |
| bus_dval | output | 1 | Registered data-valid strobe pin |
| bus_src_id | output | 5 | Source identifier pins, 5'h1F when idle |
| cap_vld | output | 1 | One-cycle capture pulse |
| cap_is_data | output | 1 | 0: address capture, 1: data capture |
| cap_value | output | 32 | Captured bus value |
| cap_id | output | 5 | Captured source identifier |
| cap_err | output | 1 | Both strobes seen together with a valid identifier |
| cap_row | output | 13 | SDRAM row field of cap_value |
| cap_bank | output | 2 | SDRAM bank field of cap_value |
| cap_col | output | 10 | SDRAM column field of cap_value |

## Verification
The bench builds the block with its default parameters: a 5-bit identifier, a 32-bit bus, and a 13/2/10 row/bank/column split. With these, a 256-cycle sweep in each mode covers every identifier value, including the reserved one. It also covers every combination of phase-valid and the two strobes, and all four port-size codes. The strap is inverted right after reset is released, so the mode-hold rule is exercised throughout each sweep, and the dual-strobe priority case occurs for every identifier.

// File: rtl/srcid_dbg_pkg.sv
// Package: shared widths, the reserved idle code and the capture record
// for the source-ID debug tagger.
package srcid_dbg_pkg;
    localparam int unsigned ID_W = 5;
    localparam int unsigned AD_W = 32;
    localparam logic [ID_W-1:0] ID_IDLE = '1;

    typedef enum logic {
        CAP_ADDR = 1'b0,
        CAP_DATA = 1'b1
    } cap_kind_e;

    typedef struct packed {
        logic            vld;
        cap_kind_e       kind;
        logic            err;
        logic [AD_W-1:0] value;
        logic [ID_W-1:0] id;
    } cap_rec_t;
endpackage

// File: rtl/srcid_mode_latch.sv
// Module: srcid_mode_latch
// Holds the tagging enable. The register follows the strap while reset is
// held and freezes once reset is released.
// Assumes the strap is stable for at least one clock edge before release.
module srcid_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    output logic mode_en
);
    // Track the strap during reset, hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_en <= strap;
        end
    end
endmodule

// File: rtl/srcid_pin_driver.sv
// Module: srcid_pin_driver
// Registers the bus value and the strobes to the pins and drives the
// source identifier. The identifier is the owner's ID during a valid phase
// with tagging enabled, and the idle code otherwise.
// Assumes the bus engine raises phase_vld for every address or data phase.
module srcid_pin_driver #(
    parameter int unsigned AD_W = 32,
    parameter int unsigned ID_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_en,
    input  logic [AD_W-1:0] in_ad,
    input  logic            in_ale,
    input  logic            in_dval,
    input  logic            in_phase_vld,
    input  logic [ID_W-1:0] in_src_id,
    output logic [AD_W-1:0] pin_ad,
    output logic            pin_ale,
    output logic            pin_dval,
    output logic [ID_W-1:0] pin_id
);
    localparam logic [ID_W-1:0] IDLE = '1;

    logic [ID_W-1:0] id_next;

    // Choose the identifier for the next pin cycle.
    always_comb begin
        id_next = IDLE;
        if (mode_en && in_phase_vld) begin
            id_next = in_src_id;
        end
    end

    // Pin registers: value, strobes, identifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_ad   <= '0;
            pin_ale  <= 1'b0;
            pin_dval <= 1'b0;
            pin_id   <= IDLE;
        end else begin
            pin_ad   <= in_ad;
            pin_ale  <= in_ale;
            pin_dval <= in_dval;
            pin_id   <= id_next;
        end
    end
endmodule

// File: rtl/srcid_capture_mon.sv
// Module: srcid_capture_mon
// Observes the driven pins and records one capture per qualifying cycle.
// An address capture needs the address-latch strobe and a valid ID. A data
// capture needs the data-valid strobe and a valid ID. When both strobes are
// high, the address wins and the error flag is raised.
// Assumes the pins are sampled on the same clock that drives them.
module srcid_capture_mon #(
    parameter int unsigned AD_W = 32,
    parameter int unsigned ID_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] pin_ad,
    input  logic            pin_ale,
    input  logic            pin_dval,
    input  logic [ID_W-1:0] pin_id,
    output logic            cap_vld,
    output logic            cap_is_data,
    output logic            cap_err,
    output logic [AD_W-1:0] cap_value,
    output logic [ID_W-1:0] cap_id
);
    localparam logic [ID_W-1:0] IDLE = '1;

    logic id_ok;
    logic take_addr;
    logic take_data;
    logic clash;

    // Qualify the strobes with a non-idle identifier and rank them.
    always_comb begin
        id_ok     = (pin_id != IDLE);
        take_addr = id_ok && pin_ale;
        take_data = id_ok && pin_dval && !pin_ale;
        clash     = id_ok && pin_ale && pin_dval;
    end

    // Pulse registers: valid, kind and error last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld     <= 1'b0;
            cap_is_data <= 1'b0;
            cap_err     <= 1'b0;
        end else begin
            cap_vld     <= take_addr || take_data;
            cap_is_data <= take_data;
            cap_err     <= clash;
        end
    end

    // Payload registers: load only on a capture, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_value <= '0;
            cap_id    <= IDLE;
        end else if (take_addr || take_data) begin
            cap_value <= pin_ad;
            cap_id    <= pin_id;
        end
    end
endmodule

// File: rtl/sdram_addr_split.sv
// Module: sdram_addr_split
// Splits a captured value into row, bank and column fields, ordered from
// the top as row, bank, column, then unconnected low bits. The number of
// low bits follows the port width code.
// Assumes the low bits plus ROW_W + BANK_W + COL_W fit in AD_W.
module sdram_addr_split #(
    parameter int unsigned AD_W   = 32,
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned COL_W  = 10
) (
    input  logic [AD_W-1:0]   value,
    input  logic [1:0]        port_size,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col
);
    localparam int unsigned MAX_LSB = 2;
    localparam int unsigned USED_W  = MAX_LSB + ROW_W + BANK_W + COL_W;

    logic [AD_W-1:0] aligned;

    initial begin
        if (USED_W > AD_W) begin
            $error("sdram_addr_split: fields exceed the bus width");
        end
    end

    // Strip the unconnected low bits selected by the port width.
    always_comb begin
        unique case (port_size)
            2'd0:    aligned = value;
            2'd1:    aligned = value >> 1;
            default: aligned = value >> 2;
        endcase
    end

    // Slice the aligned value into its fields.
    always_comb begin
        col  = aligned[COL_W-1:0];
        bank = aligned[COL_W +: BANK_W];
        row  = aligned[COL_W+BANK_W +: ROW_W];
    end
endmodule

// File: rtl/srcid_debug_tagger.sv
// Module: srcid_debug_tagger (top)
// Debug tagger for a multiplexed address/data local bus. It drives the
// transaction source identifier beside the bus value. A built-in monitor
// captures the tagged addresses and data and splits them into SDRAM fields.
// Assumes a single clock and a synchronous active-low reset.
module srcid_debug_tagger #(
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned COL_W  = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                dbg_strap,
    input  logic [1:0]                          port_size,
    input  logic [srcid_dbg_pkg::AD_W-1:0]      core_ad,
    input  logic                                core_ale,
    input  logic                                core_dval,
    input  logic                                core_phase_vld,
    input  logic [srcid_dbg_pkg::ID_W-1:0]      core_src_id,
    output logic [srcid_dbg_pkg::AD_W-1:0]      bus_ad,
    output logic                                bus_ale,
    output logic                                bus_dval,
    output logic [srcid_dbg_pkg::ID_W-1:0]      bus_src_id,
    output logic                                cap_vld,
    output logic                                cap_is_data,
    output logic [srcid_dbg_pkg::AD_W-1:0]      cap_value,
    output logic [srcid_dbg_pkg::ID_W-1:0]      cap_id,
    output logic                                cap_err,
    output logic [ROW_W-1:0]                    cap_row,
    output logic [BANK_W-1:0]                   cap_bank,
    output logic [COL_W-1:0]                    cap_col
);
    import srcid_dbg_pkg::*;

    logic     dbg_mode_q;
    cap_rec_t rec;

    srcid_mode_latch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap   (dbg_strap),
        .mode_en (dbg_mode_q)
    );

    srcid_pin_driver #(
        .AD_W (AD_W),
        .ID_W (ID_W)
    ) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_en      (dbg_mode_q),
        .in_ad        (core_ad),
        .in_ale       (core_ale),
        .in_dval      (core_dval),
        .in_phase_vld (core_phase_vld),
        .in_src_id    (core_src_id),
        .pin_ad       (bus_ad),
        .pin_ale      (bus_ale),
        .pin_dval     (bus_dval),
        .pin_id       (bus_src_id)
    );

    logic cap_is_data_w;

    srcid_capture_mon #(
        .AD_W (AD_W),
        .ID_W (ID_W)
    ) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_ad      (bus_ad),
        .pin_ale     (bus_ale),
        .pin_dval    (bus_dval),
        .pin_id      (bus_src_id),
        .cap_vld     (rec.vld),
        .cap_is_data (cap_is_data_w),
        .cap_err     (rec.err),
        .cap_value   (rec.value),
        .cap_id      (rec.id)
    );

    // Map the kind bit onto the record's enum field.
    always_comb begin
        rec.kind = cap_is_data_w ? CAP_DATA : CAP_ADDR;
    end

    sdram_addr_split #(
        .AD_W   (AD_W),
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W),
        .COL_W  (COL_W)
    ) u_split (
        .value     (rec.value),
        .port_size (port_size),
        .row       (cap_row),
        .bank      (cap_bank),
        .col       (cap_col)
    );

    // Drive the capture outputs from the record.
    always_comb begin
        cap_vld     = rec.vld;
        cap_is_data = (rec.kind == CAP_DATA);
        cap_err     = rec.err;
        cap_value   = rec.value;
        cap_id      = rec.id;
    end
endmodule

// File: rtl/srcid_debug_tagger_chk.sv
// Module: srcid_debug_tagger_chk
// Assertion checker for srcid_debug_tagger, attached by bind.
module srcid_debug_tagger_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dbg_mode_q,
    input logic        core_phase_vld,
    input logic [4:0]  core_src_id,
    input logic [4:0]  bus_src_id,
    input logic        bus_ale,
    input logic        bus_dval,
    input logic [31:0] bus_ad,
    input logic        cap_vld,
    input logic        cap_is_data,
    input logic        cap_err,
    input logic [31:0] cap_value
);
    // R3
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_mode_q && $past(rst_n)) |-> (bus_src_id == 5'h1F));

    // R4
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(dbg_mode_q));

    // R2
    tag_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode_q && core_phase_vld) |=> (bus_src_id == $past(core_src_id)));

    // R8
    no_idle_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && $past(rst_n)) |-> ($past(bus_src_id) != 5'h1F));

    // R6
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && !cap_is_data && $past(rst_n)) |->
            ($past(bus_ale) && cap_value == $past(bus_ad)));

    // R7
    data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && cap_is_data && $past(rst_n)) |->
            ($past(bus_dval) && !$past(bus_ale)));

    // R9
    clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_err |-> (cap_vld && !cap_is_data));
endmodule

bind srcid_debug_tagger srcid_debug_tagger_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dbg_mode_q     (dbg_mode_q),
    .core_phase_vld (core_phase_vld),
    .core_src_id    (core_src_id),
    .bus_src_id     (bus_src_id),
    .bus_ale        (bus_ale),
    .bus_dval       (bus_dval),
    .bus_ad         (bus_ad),
    .cap_vld        (cap_vld),
    .cap_is_data    (cap_is_data),
    .cap_err        (cap_err),
    .cap_value      (cap_value)
);

// File: tb/tb_srcid_debug_tagger.sv
module tb_srcid_debug_tagger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_strap = 1'b0;
    logic [1:0]  port_size = 2'd0;
    logic [31:0] core_ad = '0;
    logic        core_ale = 1'b0;
    logic        core_dval = 1'b0;
    logic        core_phase_vld = 1'b0;
    logic [4:0]  core_src_id = '0;
    logic [31:0] bus_ad;
    logic        bus_ale, bus_dval;
    logic [4:0]  bus_src_id;
    logic        cap_vld, cap_is_data, cap_err;
    logic [31:0] cap_value;
    logic [4:0]  cap_id;
    logic [12:0] cap_row;
    logic [1:0]  cap_bank;
    logic [9:0]  cap_col;

    int n_checks = 0;
    int n_fail = 0;

    // expected pin state from the previous cycle
    logic [31:0] p_ad;
    logic        p_ale, p_dval;
    logic [4:0]  p_id;
    logic        mode_exp;

    always #5 clk = ~clk;

    srcid_debug_tagger dut (
        .clk(clk), .rst_n(rst_n), .dbg_strap(dbg_strap), .port_size(port_size),
        .core_ad(core_ad), .core_ale(core_ale), .core_dval(core_dval),
        .core_phase_vld(core_phase_vld), .core_src_id(core_src_id),
        .bus_ad(bus_ad), .bus_ale(bus_ale), .bus_dval(bus_dval),
        .bus_src_id(bus_src_id), .cap_vld(cap_vld), .cap_is_data(cap_is_data),
        .cap_value(cap_value), .cap_id(cap_id), .cap_err(cap_err),
        .cap_row(cap_row), .cap_bank(cap_bank), .cap_col(cap_col)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0;
        dbg_strap = ~strap;
        core_ale = 1'b1; core_dval = 1'b1; core_phase_vld = 1'b1;
        core_src_id = 5'd3; core_ad = 32'hFFFF_0000;
        @(negedge clk);
        dbg_strap = strap;
        @(negedge clk);
        @(negedge clk);
        chk("R1 id", {27'd0, bus_src_id}, 32'h1F);
        chk("R1 ale", {31'd0, bus_ale}, 0);
        chk("R1 dval", {31'd0, bus_dval}, 0);
        chk("R1 ad", bus_ad, 0);
        chk("R1 cap_vld", {31'd0, cap_vld}, 0);
        chk("R1 cap_err", {31'd0, cap_err}, 0);
        rst_n = 1'b1;
        mode_exp = strap;
        p_ad = '0; p_ale = 1'b0; p_dval = 1'b0; p_id = 5'h1F;
    endtask

    // Apply one cycle of inputs at a negedge, check at the next negedge.
    task automatic step(input logic [31:0] ad, input logic ale, input logic dv,
                        input logic ph, input logic [4:0] sid, input logic [1:0] ps);
        logic [4:0] e_id;
        logic       e_vld;
        int         lsb;
        logic [31:0] al;
        core_ad = ad; core_ale = ale; core_dval = dv;
        core_phase_vld = ph; core_src_id = sid; port_size = ps;
        @(negedge clk);
        e_id = (mode_exp && ph) ? sid : 5'h1F;
        if (mode_exp) chk("R2 tag", {27'd0, bus_src_id}, {27'd0, e_id});
        else          chk("R3 idle", {27'd0, bus_src_id}, 32'h1F);
        chk("R5 ad", bus_ad, ad);
        chk("R5 strobes", {30'd0, bus_ale, bus_dval}, {30'd0, ale, dv});
        e_vld = (p_id != 5'h1F) && (p_ale || p_dval);
        if (!e_vld) chk("R8 no capture", {31'd0, cap_vld}, 0);
        else if (p_ale) chk("R6 addr vld", {30'd0, cap_vld, cap_is_data}, 32'h2);
        else            chk("R7 data vld", {30'd0, cap_vld, cap_is_data}, 32'h3);
        chk("R9 err", {31'd0, cap_err}, {31'd0, e_vld && p_ale && p_dval});
        if (e_vld) begin
            chk(p_ale ? "R6 value" : "R7 value", cap_value, p_ad);
            chk(p_ale ? "R6 id" : "R7 id", {27'd0, cap_id}, {27'd0, p_id});
            lsb = (ps == 2'd0) ? 0 : ((ps == 2'd1) ? 1 : 2);
            al = p_ad >> lsb;
            chk("R10 col", {22'd0, cap_col}, al % 1024);
            chk("R10 bank", {30'd0, cap_bank}, (al / 1024) % 4);
            chk("R10 row", {19'd0, cap_row}, (al / 4096) % 8192);
        end
        p_ad = ad; p_ale = ale; p_dval = dv; p_id = e_id;
    endtask

    initial begin
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            // R4: strap flips after release and must be ignored
            dbg_strap = ~m[0];
            for (int i = 0; i < 256; i++) begin
                logic [31:0] v;
                v = (32'h9E37_79B9 * (i + 1)) ^ (i << 7);
                step(v, i[6], i[7], i[5], i[4:0], i[1:0] ^ i[3:2]);
            end
            step(32'h0, 1'b0, 1'b0, 1'b0, 5'd0, 2'd0);
            step(32'h0, 1'b0, 1'b0, 1'b0, 5'd0, 2'd0);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule